// File: doc/BRIEF.md
# Parallel-to-Serial Pin Multiplexer

This block lets a large number of internal timer, PWM and general-purpose signals share a handful of device pins. It combines four 16-bit internal signal groups into one serial word and shifts that word out to an external expander over a synchronous link. It also shifts a return word in and presents its first sixteen bits on an internal input bus. Software sets the link through a small write-only register port. The settings are the number of bits per frame, the serial clock divider, the clocking style (chip-select framing or free-running clock with a sync pulse) and the run style (repeating frames or one frame per start command).

An internal loopback setting wraps the transmitted bits straight back into the receive path. While it is on, the external data pins are unused: the transmit pin stays low and the receive pin is ignored. The four parallel groups are frozen into a shadow register when each frame begins, so every bit of one frame comes from the same clock cycle.

Top module: `pinmux_serializer`

## Requirements
- R1: While reset is held and after its release, `gpi_o` is 0, `done_o` is 0, `tclk_o` and `txd_o` are low and `sync_o` is high. The link stays disabled until software enables it.
- R2: A write with `cfg_addr_i`=0 sets the control bits: bit 0 enable, bit 1 repeat, bit 2 free-clock framing, bit 3 loopback. Bit 4 is a start strobe that is honoured only when bit 0 is set in the same write. Address 1 holds the frame length minus one in its low 6 bits. Address 2 holds the clock divider. A write to address 3 changes nothing.
- R3: A frame carries N = length+1 bits (1 to 64) with exactly N rising edges of `tclk_o`. Bit k of the frame is bit k of {lane3_i, lane2_i, lane1_i, lane0_i}, so lane 0 goes first, least significant bit first.
- R4: Each half period of `tclk_o` lasts divider+1 system clocks, so rising edges within a frame are 2*(divider+1) clocks apart.
- R5: With free-clock framing off, `sync_o` is an active-low select. It is low for the whole frame and high when no frame runs, and it rises only at frame end or on disable. `tclk_o` stays low outside frames. `txd_o` changes on falling edges and `rxd_i` is sampled on rising edges.
- R6: With free-clock framing on, `tclk_o` toggles whenever the link is enabled, even between frames. `sync_o` is high exactly during bit 0 of each frame, and a frame begins while `tclk_o` is low.
- R7: With repeat off, each honoured start produces exactly one frame and then the link goes quiet. A start written while the enable bit is 0 produces no frame, and it does not produce one later when the link is enabled.
- R8: With repeat on, frames follow each other with no idle bit time between them. After repeat is cleared, the frame in progress finishes and no further frame starts.
- R9: The lanes are captured at frame start. A lane change during a frame does not alter the bits sent in that frame.
- R10: At the end of a frame `done_o` pulses for one clock and `gpi_o` takes the new value in that same cycle. Bit i of `gpi_o` holds the i-th received bit for i < min(N,16) and 0 for the other bits. `gpi_o` never changes in any other cycle.
- R11: With loopback on, each received bit is the bit being transmitted internally, `rxd_i` is ignored and `txd_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | 8 | Register write data |
| lane0_i | input | 16 | Parallel group 0 (first on the wire) |
| lane1_i | input | 16 | Parallel group 1 |
| lane2_i | input | 16 | Parallel group 2 |
| lane3_i | input | 16 | Parallel group 3 |
| gpi_o | output | 16 | Received inputs, updated per frame |
| done_o | output | 1 | One-clock frame completion pulse |
| tclk_o | output | 1 | Serial link clock |
| sync_o | output | 1 | Frame select (active low) or frame sync pulse |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |

## Verification
The assertions check on every cycle that `done_o` is a single-cycle pulse and that `gpi_o` moves only together with it. They also check that loopback keeps the transmit pin quiet, that a free-clock frame begins while the clock is low, and that the select line is released only at frame end or on disable. The bench's scenarios are needed for the rest: bit order and bit count per frame, clock period against the divider, capture of the lanes at frame start, one frame per start against back-to-back repetition, and a start ignored while the link is disabled. These depend on whole frames compared against a model of the external device.

// File: rtl/ppmx_pkg.sv
package ppmx_pkg;
    // Control register layout: bit0 enable, bit1 repeat, bit2 free clock, bit3 loopback
    typedef struct packed {
        logic shorted;
        logic tdm;
        logic cont;
        logic en;
    } ppmx_ctl_t;
endpackage

// File: rtl/ppmx_cfg.sv
module ppmx_cfg
    import ppmx_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [DIV_W-1:0] wdata_i,
    output ppmx_ctl_t        ctl_o,
    output logic [IDX_W-1:0] len_o,
    output logic [DIV_W-1:0] div_o,
    output logic             start_o
);
    typedef struct packed {
        ppmx_ctl_t        ctl;
        logic [IDX_W-1:0] len;
        logic [DIV_W-1:0] div;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            case (addr_i)
                2'd0:    cfg_d.ctl = ppmx_ctl_t'(wdata_i[3:0]);
                2'd1:    cfg_d.len = wdata_i[IDX_W-1:0];
                2'd2:    cfg_d.div = wdata_i;
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.ctl <= '0;
            cfg_q.len <= IDX_W'(15);
            cfg_q.div <= DIV_W'(3);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // start strobe only counts when the same write also enables the link
    assign start_o = wr_i && (addr_i == 2'd0) && wdata_i[4] && wdata_i[0];
    assign ctl_o   = cfg_q.ctl;
    assign len_o   = cfg_q.len;
    assign div_o   = cfg_q.div;
endmodule

// File: rtl/ppmx_timebase.sv
module ppmx_timebase #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tclk_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tclk;
    } tb_s;

    tb_s tb_d, tb_q;
    logic term;

    assign term = en_i && (tb_q.cnt >= div_i);

    always_comb begin
        tb_d = tb_q;
        if (!en_i) begin
            tb_d.cnt  = '0;
            tb_d.tclk = 1'b0;
        end else if (term) begin
            tb_d.cnt  = '0;
            tb_d.tclk = ~tb_q.tclk;
        end else begin
            tb_d.cnt = tb_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign tclk_o = tb_q.tclk;
    assign rise_o = term && !tb_q.tclk;
    assign fall_o = term &&  tb_q.tclk;
endmodule

// File: rtl/ppmx_frame.sv
module ppmx_frame
    import ppmx_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int IDX_W  = 6,
    localparam int SW    = 4 * LANE_W,
    localparam int RX_B  = $clog2(LANE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ppmx_ctl_t         ctl_i,
    input  logic [IDX_W-1:0]  len_i,
    input  logic              start_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic [SW-1:0]     stream_i,
    input  logic              rxd_i,
    output logic              txd_o,
    output logic [LANE_W-1:0] gpi_o,
    output logic              done_o,
    output logic              active_o,
    output logic [IDX_W-1:0]  idx_o
);
    typedef struct packed {
        logic              active;
        logic              pend;
        logic [IDX_W-1:0]  idx;
        logic [SW-1:0]     shadow;
        logic [LANE_W-1:0] rxsr;
        logic [LANE_W-1:0] gpi;
        logic              tx;
        logic              done;
    } fr_s;

    fr_s fr_d, fr_q;
    logic             last_bit;
    logic [IDX_W-1:0] idx_inc;

    assign last_bit = fr_q.active && (fr_q.idx >= len_i);
    assign idx_inc  = fr_q.idx + IDX_W'(1);

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;

        // sample on the rising edge of the link clock
        if (rise_i && fr_q.active && (fr_q.idx < IDX_W'(LANE_W)))
            fr_d.rxsr[fr_q.idx[RX_B-1:0]] = ctl_i.shorted ? fr_q.shadow[fr_q.idx] : rxd_i;

        // advance on the falling edge
        if (fall_i) begin
            if (last_bit) begin
                fr_d.done   = 1'b1;
                fr_d.gpi    = fr_q.rxsr;
                fr_d.active = 1'b0;
                fr_d.tx     = 1'b0;
            end
            if (fr_q.active && !last_bit) begin
                fr_d.idx = idx_inc;
                fr_d.tx  = fr_q.shadow[idx_inc];
            end else if (ctl_i.cont || fr_q.pend) begin
                fr_d.active = 1'b1;
                fr_d.pend   = 1'b0;
                fr_d.idx    = '0;
                fr_d.shadow = stream_i;
                fr_d.rxsr   = '0;
                fr_d.tx     = stream_i[0];
            end
        end

        if (ctl_i.shorted) fr_d.tx = 1'b0;

        if (!ctl_i.en) begin
            fr_d.active = 1'b0;
            fr_d.pend   = 1'b0;
            fr_d.idx    = '0;
            fr_d.tx     = 1'b0;
        end

        if (start_i) fr_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign txd_o    = fr_q.tx;
    assign gpi_o    = fr_q.gpi;
    assign done_o   = fr_q.done;
    assign active_o = fr_q.active;
    assign idx_o    = fr_q.idx;
endmodule

// File: rtl/pinmux_serializer.sv
module pinmux_serializer
    import ppmx_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int DIV_W  = 8,
    localparam int SW    = 4 * LANE_W,
    localparam int IDX_W = $clog2(SW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [1:0]        cfg_addr_i,
    input  logic [DIV_W-1:0]  cfg_wdata_i,
    input  logic [LANE_W-1:0] lane0_i,
    input  logic [LANE_W-1:0] lane1_i,
    input  logic [LANE_W-1:0] lane2_i,
    input  logic [LANE_W-1:0] lane3_i,
    output logic [LANE_W-1:0] gpi_o,
    output logic              done_o,
    output logic              tclk_o,
    output logic              sync_o,
    output logic              txd_o,
    input  logic              rxd_i
);
    ppmx_ctl_t        ctl;
    logic [IDX_W-1:0] len;
    logic [DIV_W-1:0] div;
    logic             start;
    logic             tclk_int, rise, fall;
    logic             frame_active;
    logic [IDX_W-1:0] frame_idx;

    ppmx_cfg #(.IDX_W(IDX_W), .DIV_W(DIV_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .ctl_o(ctl), .len_o(len), .div_o(div), .start_o(start)
    );

    ppmx_timebase #(.DIV_W(DIV_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .en_i(ctl.en), .div_i(div),
        .tclk_o(tclk_int), .rise_o(rise), .fall_o(fall)
    );

    ppmx_frame #(.LANE_W(LANE_W), .IDX_W(IDX_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .len_i(len), .start_i(start),
        .rise_i(rise), .fall_i(fall), .stream_i({lane3_i, lane2_i, lane1_i, lane0_i}),
        .rxd_i(rxd_i), .txd_o(txd_o), .gpi_o(gpi_o), .done_o(done_o),
        .active_o(frame_active), .idx_o(frame_idx)
    );

    // free-clock framing: clock always runs, sync marks bit 0
    // select framing: clock gated to the frame, active-low select
    always_comb begin
        if (ctl.tdm) begin
            tclk_o = tclk_int;
            sync_o = frame_active && (frame_idx == '0);
        end else begin
            tclk_o = tclk_int && frame_active;
            sync_o = !frame_active;
        end
    end
endmodule

// File: rtl/ppmx_checker.sv
module ppmx_checker #(
    parameter int LANE_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              done_i,
    input logic [LANE_W-1:0] gpi_i,
    input logic              tclk_i,
    input logic              sync_i,
    input logic              txd_i,
    input logic              tdm_i,
    input logic              shorted_i,
    input logic              en_i
);
    assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    assert_gpi_only_on_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(gpi_i) |-> done_i);

    assert_loopback_tx_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(shorted_i) |-> !txd_i);

    assert_sync_starts_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tdm_i && $past(tdm_i) && $rose(sync_i)) |-> !tclk_i);

    assert_select_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tdm_i && $past(!tdm_i) && $rose(sync_i)) |-> (done_i || !en_i));
endmodule

bind pinmux_serializer ppmx_checker #(.LANE_W(LANE_W)) u_chk (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done_o), .gpi_i(gpi_o), .tclk_i(tclk_o),
    .sync_i(sync_o), .txd_i(txd_o), .tdm_i(ctl.tdm), .shorted_i(ctl.shorted), .en_i(ctl.en)
);

// File: tb/pinmux_serializer_test.sv
module pinmux_serializer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] l0 = '0, l1 = '0, l2 = '0, l3 = '0;
    logic [15:0] gpi;
    logic        done, tclk, sync, txd, rxd;

    pinmux_serializer uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
        .cfg_wdata_i(cfg_wdata), .lane0_i(l0), .lane1_i(l1), .lane2_i(l2), .lane3_i(l3),
        .gpi_o(gpi), .done_o(done), .tclk_o(tclk), .sync_o(sync), .txd_o(txd), .rxd_i(rxd)
    );

    int n_cmp = 0, n_bad = 0;
    bit b_tdm = 0, b_cont = 0;
    int b_div = 0;
    logic [63:0] ext_word = '0;
    int rises = 0, total_rises = 0, frames = 0, last_n = 0, cyc = 0, last_rise_cyc = 0;
    logic [63:0] cap = '0, last_cap = '0;
    logic prev_tclk = 1'b0, prev_sync = 1'b1;
    bit in_frame = 0;

    // external device: presents bit k of its word before the k-th rising edge
    assign rxd = ext_word[rises & 63];

    task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mask_n(int n);
        return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
    endfunction

    function automatic logic [15:0] exp_gpi(logic [63:0] strm, logic [63:0] ext, int n, bit sh);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++)
            if (i < n) r[i] = sh ? strm[i] : ext[i];
        return r;
    endfunction

    always @(negedge clk) begin
        bit start_evt;
        cyc++;
        start_evt = b_tdm ? (sync === 1'b1 && prev_sync === 1'b0)
                          : (sync === 1'b0 && prev_sync === 1'b1);
        if (done === 1'b1) begin
            frames++;
            last_cap = cap;
            last_n = rises;
        end
        if (done === 1'b1 || start_evt) begin
            rises = 0;
            cap = '0;
        end
        if (start_evt) in_frame = 1;
        else if (done === 1'b1 && !b_cont) in_frame = 0;
        if (tclk === 1'b1 && prev_tclk === 1'b0) begin
            if (in_frame) begin
                if (rises > 0) check_eq("R4 tclk period", 64'(cyc - last_rise_cyc), 64'(2 * (b_div + 1)));
                if (b_tdm) check_eq("R6 sync only in bit 0", 64'(sync), 64'(rises == 0));
                else       check_eq("R5 select low in frame", 64'(sync), 64'd0);
                if (rises < 64) cap[rises] = txd;
            end
            last_rise_cyc = cyc;
            rises++;
            total_rises++;
        end
        prev_tclk = tclk;
        prev_sync = sync;
    end

    task automatic cfg_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_link(int len_m1, int div, bit sh, bit tdm, bit cont);
        b_tdm = tdm; b_cont = cont; b_div = div;
        cfg_write(2'd1, 8'(len_m1));
        cfg_write(2'd2, 8'(div));
        cfg_write(2'd0, {4'b0, sh, tdm, cont, 1'b1});
    endtask

    task automatic wait_done(int limit);
        int t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (done !== 1'b1 && t < limit);
        check_eq("R7 frame completes", 64'(done), 64'd1);
        @(negedge clk);
    endtask

    task automatic verify(int n, bit sh, logic [63:0] strm, logic [63:0] ext);
        check_eq("R3 rising edges per frame (R2 unused address)", 64'(last_n), 64'(n));
        check_eq(sh ? "R11 tx quiet in loopback" : "R3 bit order on txd",
                 last_cap, sh ? 64'd0 : (strm & mask_n(n)));
        check_eq(sh ? "R11 loopback gpi" : "R10 gpi from frame",
                 64'(gpi), 64'(exp_gpi(strm, ext, n, sh)));
    endtask

    task automatic randomize_lanes();
        l0 = 16'($urandom); l1 = 16'($urandom); l2 = 16'($urandom); l3 = 16'($urandom);
        ext_word = {$urandom, $urandom};
    endtask

    task automatic run_str(int len_m1, int div, bit sh, bit tdm);
        int lim, f1;
        logic [63:0] strm;
        randomize_lanes();
        strm = {l3, l2, l1, l0};
        set_link(len_m1, div, sh, tdm, 0);
        cfg_write(2'd3, 8'($urandom));
        repeat (3) @(negedge clk);
        lim = 4 * 64 * (div + 1) + 200;
        cfg_write(2'd0, {3'b0, 1'b1, sh, tdm, 1'b0, 1'b1});
        wait_done(lim);
        verify(len_m1 + 1, sh, strm, ext_word);
        f1 = frames;
        repeat (4 * (len_m1 + 1) * (div + 1) + 20) @(negedge clk);
        check_eq("R7 single frame per start", 64'(frames), 64'(f1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int f0, t0;
        logic [63:0] strm;
        void'($urandom(32'd4711));

        // R1 reset state
        repeat (3) @(negedge clk);
        check_eq("R1 gpi in reset", 64'(gpi), 64'd0);
        check_eq("R1 done in reset", 64'(done), 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R1 tclk/txd/sync after reset", {61'd0, tclk, txd, sync}, 64'd1);
        check_eq("R1 gpi after reset", 64'(gpi), 64'd0);

        // directed boundaries
        run_str(63, 0, 0, 0);
        run_str(0, 2, 0, 1);
        run_str(15, 1, 1, 0);
        run_str(0, 0, 1, 1);
        run_str(16, 3, 0, 0);

        // random frames
        for (int k = 0; k < 16; k++)
            run_str($urandom_range(63), $urandom_range(3), 1'($urandom_range(1)), 1'($urandom_range(1)));

        // R7 start ignored while disabled
        b_tdm = 0;
        cfg_write(2'd0, 8'h00);
        f0 = frames; t0 = total_rises;
        cfg_write(2'd0, 8'h10);
        repeat (400) @(negedge clk);
        cfg_write(2'd0, 8'h01);
        repeat (400) @(negedge clk);
        check_eq("R7 disabled start ignored", 64'(frames), 64'(f0));
        check_eq("R5 no clock without frame", 64'(total_rises), 64'(t0));

        // R6 free-running clock in idle
        set_link(7, 1, 0, 1, 0);
        t0 = total_rises;
        repeat (100) @(negedge clk);
        check_eq("R6 clock runs while idle", 64'(total_rises > t0), 64'd1);

        // R8 back-to-back frames
        randomize_lanes();
        strm = {l3, l2, l1, l0};
        set_link(7, 1, 0, 1, 1);
        for (int k = 0; k < 3; k++) begin
            wait_done(400);
            verify(8, 0, strm, ext_word);
        end
        t0 = cyc;
        wait_done(400);
        check_eq("R8 no idle gap between frames", 64'(cyc - t0), 64'(8 * 4));
        cfg_write(2'd0, 8'h05);
        b_cont = 0;
        wait_done(400);
        f0 = frames;
        repeat (300) @(negedge clk);
        check_eq("R8 repeat stops after clear", 64'(frames), 64'(f0));

        // R9 lanes captured at frame start
        randomize_lanes();
        strm = {l3, l2, l1, l0};
        set_link(31, 1, 0, 0, 0);
        cfg_write(2'd0, 8'h11);
        t0 = 0;
        while (!(in_frame && rises >= 3) && t0 < 1000) begin
            @(negedge clk);
            t0++;
        end
        l0 = ~l0; l1 = ~l1;
        wait_done(600);
        verify(32, 0, strm, ext_word);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule